// File: doc/BRIEF.md
# Interleaved Ramp-ADC Digital Back-End

This block turns the raw output of six time-to-digital converters into one stream of corrected sample codes. Each converter belongs to a single-slope converter: a clock edge launches an RC ramp, a comparator switches once the ramp passes the input voltage, and a tapped delay line captures that switching moment as a thermometer code. The six converters run on six phases of one clock, so taken together they sample at six times that clock's rate.

A frame holds one thermometer code per channel plus a presence bit per channel. The block decodes every code to a tap count, tolerating a single bubble. It drops taps beyond a per-channel length limit, so that each line covers exactly one clock period. It then subtracts a per-channel edge offset, applies a per-channel ramp gain and ramp offset, and adds a per-channel phase-alignment offset. The result is clamped to an 8-bit code. The six results are then sent out one per cycle in phase order, each with a valid flag, its phase index and an error flag.

Coefficients are written through a small write port. They are taken up only at the moment a frame is accepted, so every sample of a frame uses the same coefficient set.

Top module: `radc_backend`

## Requirements
- R1: After reset, `smp_vld` is 0. Every channel's coefficients take their defaults: length limit = TAPS, edge offset 0, gain 1.0, ramp offset 0, phase offset 0.
- R2: The tap count of a channel is the number of consecutive 1s in its thermometer code, counted from bit 0 upward. Channel c occupies bits `[c*TAPS +: TAPS]` of `frame_therm`.
- R3: A single 0 is counted as a 1 when the taps directly below and above it are both 1. Two or more adjacent 0s end the count.
- R4: Taps at index greater than or equal to the channel's length limit are treated as 0. A limit of 0 gives a count of 0.
- R5: The channel's edge offset is subtracted from the tap count as a signed difference.
- R6: The difference is multiplied by the unsigned gain, which has 8 fraction bits (256 = 1.0), and rounded toward minus infinity. The signed ramp offset is then added, followed by the signed phase offset.
- R7: The final value is clamped: results below 0 give code 0, and results above 255 give code 255.
- R8: A channel whose presence bit is 0, or whose tap count is 0, produces a sample with `smp_err` = 1 and `smp_code` = 0.
- R9: An accepted frame produces six samples on six consecutive cycles, starting the cycle after acceptance, with `smp_phase` counting 0 to 5. `smp_vld` falls afterwards unless another frame follows.
- R10: A frame is accepted when the output is idle or is showing phase 5. A frame offered at any other time is ignored entirely.
- R11: A coefficient write made while a frame is being sent does not alter that frame. It applies from the next accepted frame onward.
- R12: A write with `cfg_wr` = 1 updates channel `cfg_ch`. The field is chosen by `cfg_sel`: 0 = length limit (low 7 bits), 1 = edge offset (low 7 bits), 2 = gain (9 bits), 3 = ramp offset (low 8 bits, two's complement), 4 = phase offset (low 8 bits, two's complement). Writes with `cfg_ch` of 6 or more, or with `cfg_sel` of 5 to 7, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_vld | input | 1 | A frame of codes is offered this cycle |
| frame_therm | input | NCH*TAPS | Thermometer codes, channel c at bits c*TAPS upward |
| frame_present | input | NCH | Per-channel code present flag |
| cfg_wr | input | 1 | Coefficient write strobe |
| cfg_ch | input | clog2(NCH) | Channel addressed by the write |
| cfg_sel | input | 3 | Coefficient field selector |
| cfg_data | input | GAIN_W | Write data |
| smp_vld | output | 1 | Output sample valid |
| smp_phase | output | clog2(NCH) | Phase index of the output sample |
| smp_code | output | 8 | Corrected sample code |
| smp_err | output | 1 | Sample has no usable code |

## Verification
The bench builds the block with its defaults: six channels, 64 taps, a 9-bit gain and 8-bit offsets. With 64 taps, a gain near 2.0 and maximum positive offsets, the corrected value climbs well past 255, so the upper clamp is reached. An edge offset larger than the count drives the value negative and reaches the lower clamp. Six channels on a 3-bit channel index leave two channel numbers unused, which exercises the ignored-write path. The bench also covers back-to-back frames, a frame offered during output that must be ignored, and coefficient changes made in the middle of a frame.

// File: rtl/radc_pkg.sv
package radc_pkg;
    localparam int OUT_W  = 8;
    localparam int FRAC_W = 8;

    typedef enum logic [2:0] {
        CSEL_LIMIT = 3'd0,
        CSEL_EDGE  = 3'd1,
        CSEL_GAIN  = 3'd2,
        CSEL_RAMP  = 3'd3,
        CSEL_PHASE = 3'd4
    } csel_e;

    typedef struct packed {
        logic             err;
        logic [OUT_W-1:0] code;
    } sample_t;
endpackage

// File: rtl/radc_therm_decode.sv
module radc_therm_decode #(
    parameter int TAPS  = 64,
    parameter int CNT_W = $clog2(TAPS + 1)
) (
    input  logic [TAPS-1:0]  therm,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] count
);
    logic [TAPS-1:0] kept;
    logic [TAPS-1:0] healed;

    // trim the line to the programmed length, then fill lone bubbles
    for (genvar i = 0; i < TAPS; i++) begin : g_tap
        assign kept[i] = therm[i] & (CNT_W'(i) < limit);
        if (i == 0 || i == TAPS - 1) begin : g_edge
            assign healed[i] = kept[i];
        end else begin : g_mid
            assign healed[i] = kept[i] | (kept[i-1] & kept[i+1]);
        end
    end

    // length of the run of ones starting at tap 0
    always_comb begin : p_count
        logic run;
        run   = 1'b1;
        count = '0;
        for (int i = 0; i < TAPS; i++) begin
            run   = run & healed[i];
            count = count + CNT_W'(run);
        end
    end
endmodule

// File: rtl/radc_chan_correct.sv
module radc_chan_correct
    import radc_pkg::*;
#(
    parameter int CNT_W  = 7,
    parameter int GAIN_W = 9,
    parameter int OFS_W  = 8
) (
    input  logic                    present,
    input  logic [CNT_W-1:0]        count,
    input  logic [CNT_W-1:0]        edge_off,
    input  logic [GAIN_W-1:0]       gain,
    input  logic signed [OFS_W-1:0] ramp_off,
    input  logic signed [OFS_W-1:0] phase_off,
    output sample_t                 result
);
    localparam int ACC_W = CNT_W + GAIN_W + 4;
    localparam logic signed [ACC_W-1:0] TOP = ACC_W'((1 << OUT_W) - 1);

    logic signed [ACC_W-1:0] diff;
    logic signed [ACC_W-1:0] prod;
    logic signed [ACC_W-1:0] scaled;
    logic signed [ACC_W-1:0] total;

    always_comb begin
        // stage order: edge offset, ramp gain, ramp offset, phase alignment
        diff   = $signed(ACC_W'(count)) - $signed(ACC_W'(edge_off));
        prod   = diff * $signed(ACC_W'(gain));
        scaled = prod >>> FRAC_W;
        total  = scaled + ACC_W'(ramp_off) + ACC_W'(phase_off);

        result.err = !present || (count == '0);
        if (result.err) begin
            result.code = '0;
        end else if (total < 0) begin
            result.code = '0;
        end else if (total > TOP) begin
            result.code = '1;
        end else begin
            result.code = total[OUT_W-1:0];
        end
    end
endmodule

// File: rtl/radc_coef_bank.sv
module radc_coef_bank
    import radc_pkg::*;
#(
    parameter int NCH    = 6,
    parameter int TAPS   = 64,
    parameter int CNT_W  = 7,
    parameter int GAIN_W = 9,
    parameter int OFS_W  = 8,
    parameter int CH_W   = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [CH_W-1:0]               wr_ch,
    input  logic [2:0]                    wr_sel,
    input  logic [GAIN_W-1:0]             wr_data,
    output logic [NCH-1:0][CNT_W-1:0]     limit,
    output logic [NCH-1:0][CNT_W-1:0]     edge_off,
    output logic [NCH-1:0][GAIN_W-1:0]    gain,
    output logic [NCH-1:0][OFS_W-1:0]     ramp_off,
    output logic [NCH-1:0][OFS_W-1:0]     phase_off
);
    typedef struct packed {
        logic [NCH-1:0][CNT_W-1:0]  limit;
        logic [NCH-1:0][CNT_W-1:0]  edge_off;
        logic [NCH-1:0][GAIN_W-1:0] gain;
        logic [NCH-1:0][OFS_W-1:0]  ramp_off;
        logic [NCH-1:0][OFS_W-1:0]  phase_off;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (wr_en && (wr_ch < CH_W'(NCH))) begin
            case (csel_e'(wr_sel))
                CSEL_LIMIT: bank_d.limit[wr_ch]     = wr_data[CNT_W-1:0];
                CSEL_EDGE:  bank_d.edge_off[wr_ch]  = wr_data[CNT_W-1:0];
                CSEL_GAIN:  bank_d.gain[wr_ch]      = wr_data;
                CSEL_RAMP:  bank_d.ramp_off[wr_ch]  = wr_data[OFS_W-1:0];
                CSEL_PHASE: bank_d.phase_off[wr_ch] = wr_data[OFS_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                bank_q.limit[c]     <= CNT_W'(TAPS);
                bank_q.edge_off[c]  <= '0;
                bank_q.gain[c]      <= GAIN_W'(1 << FRAC_W);
                bank_q.ramp_off[c]  <= '0;
                bank_q.phase_off[c] <= '0;
            end
        end else begin
            bank_q <= bank_d;
        end
    end

    assign limit     = bank_q.limit;
    assign edge_off  = bank_q.edge_off;
    assign gain      = bank_q.gain;
    assign ramp_off  = bank_q.ramp_off;
    assign phase_off = bank_q.phase_off;
endmodule

// File: rtl/radc_merge.sv
module radc_merge
    import radc_pkg::*;
#(
    parameter int NCH  = 6,
    parameter int PH_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_vld,
    input  sample_t [NCH-1:0]   lanes,
    output logic                out_vld,
    output logic [PH_W-1:0]     out_phase,
    output sample_t             out_smp
);
    localparam logic [PH_W-1:0] LAST = PH_W'(NCH - 1);

    typedef struct packed {
        logic              busy;
        logic [PH_W-1:0]   slot;
        sample_t [NCH-1:0] held;
    } mst_t;

    mst_t st_d, st_q;
    logic take;

    always_comb begin
        take = frame_vld && (!st_q.busy || st_q.slot == LAST);
        st_d = st_q;
        if (take) begin
            st_d.busy = 1'b1;
            st_d.slot = '0;
            st_d.held = lanes;
        end else if (st_q.busy) begin
            if (st_q.slot == LAST) begin
                st_d.busy = 1'b0;
                st_d.slot = '0;
            end else begin
                st_d.slot = st_q.slot + PH_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_vld   = st_q.busy;
    assign out_phase = st_q.slot;
    assign out_smp   = st_q.held[st_q.slot];
endmodule

// File: rtl/radc_backend.sv
module radc_backend
    import radc_pkg::*;
#(
    parameter int NCH    = 6,
    parameter int TAPS   = 64,
    parameter int GAIN_W = 9,
    parameter int OFS_W  = 8,
    localparam int CNT_W = $clog2(TAPS + 1),
    localparam int CH_W  = $clog2(NCH),
    localparam int PH_W  = CH_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   frame_vld,
    input  logic [NCH*TAPS-1:0]    frame_therm,
    input  logic [NCH-1:0]         frame_present,
    input  logic                   cfg_wr,
    input  logic [CH_W-1:0]        cfg_ch,
    input  logic [2:0]             cfg_sel,
    input  logic [GAIN_W-1:0]      cfg_data,
    output logic                   smp_vld,
    output logic [PH_W-1:0]        smp_phase,
    output logic [OUT_W-1:0]       smp_code,
    output logic                   smp_err
);
    logic [NCH-1:0][CNT_W-1:0]  limit;
    logic [NCH-1:0][CNT_W-1:0]  edge_off;
    logic [NCH-1:0][GAIN_W-1:0] gain;
    logic [NCH-1:0][OFS_W-1:0]  ramp_off;
    logic [NCH-1:0][OFS_W-1:0]  phase_off;
    logic [NCH-1:0][CNT_W-1:0]  count;
    sample_t [NCH-1:0]          lanes;
    sample_t                    smp;

    radc_coef_bank #(
        .NCH(NCH), .TAPS(TAPS), .CNT_W(CNT_W),
        .GAIN_W(GAIN_W), .OFS_W(OFS_W), .CH_W(CH_W)
    ) u_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_wr), .wr_ch(cfg_ch), .wr_sel(cfg_sel), .wr_data(cfg_data),
        .limit(limit), .edge_off(edge_off), .gain(gain),
        .ramp_off(ramp_off), .phase_off(phase_off)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_lane
        radc_therm_decode #(.TAPS(TAPS), .CNT_W(CNT_W)) u_dec (
            .therm(frame_therm[c*TAPS +: TAPS]),
            .limit(limit[c]),
            .count(count[c])
        );
        radc_chan_correct #(.CNT_W(CNT_W), .GAIN_W(GAIN_W), .OFS_W(OFS_W)) u_cor (
            .present(frame_present[c]),
            .count(count[c]),
            .edge_off(edge_off[c]),
            .gain(gain[c]),
            .ramp_off(ramp_off[c]),
            .phase_off(phase_off[c]),
            .result(lanes[c])
        );
    end

    radc_merge #(.NCH(NCH), .PH_W(PH_W)) u_merge (
        .clk(clk), .rst_n(rst_n),
        .frame_vld(frame_vld),
        .lanes(lanes),
        .out_vld(smp_vld),
        .out_phase(smp_phase),
        .out_smp(smp)
    );

    assign smp_code = smp.code;
    assign smp_err  = smp.err;
endmodule

// File: rtl/radc_backend_chk.sv
module radc_backend_chk #(
    parameter int NCH  = 6,
    parameter int PH_W = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            frame_vld,
    input logic            smp_vld,
    input logic [PH_W-1:0] smp_phase,
    input logic [7:0]      smp_code,
    input logic            smp_err
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> !smp_vld);

    assert_phase_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && smp_phase != PH_W'(NCH - 1)) |=>
        (smp_vld && smp_phase == $past(smp_phase) + PH_W'(1)));

    assert_stream_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && !$past(smp_vld)) |-> (smp_phase == '0));

    assert_idle_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_vld && !smp_vld) |=> (smp_vld && smp_phase == '0));

    assert_last_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && smp_phase == PH_W'(NCH - 1) && !frame_vld) |=> !smp_vld);

    assert_err_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && smp_err) |-> (smp_code == 8'd0));
endmodule

bind radc_backend radc_backend_chk #(.NCH(NCH), .PH_W(PH_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .frame_vld(frame_vld), .smp_vld(smp_vld),
    .smp_phase(smp_phase), .smp_code(smp_code), .smp_err(smp_err)
);

// File: tb/tb_radc_backend.sv
module tb_radc_backend;
    localparam int NCH  = 6;
    localparam int TAPS = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              frame_vld = 1'b0;
    logic [NCH*TAPS-1:0] frame_therm = '0;
    logic [NCH-1:0]    frame_present = '0;
    logic              cfg_wr = 1'b0;
    logic [2:0]        cfg_ch = '0;
    logic [2:0]        cfg_sel = '0;
    logic [8:0]        cfg_data = '0;
    logic              smp_vld;
    logic [2:0]        smp_phase;
    logic [7:0]        smp_code;
    logic              smp_err;

    radc_backend dut (
        .clk(clk), .rst_n(rst_n), .frame_vld(frame_vld), .frame_therm(frame_therm),
        .frame_present(frame_present), .cfg_wr(cfg_wr), .cfg_ch(cfg_ch),
        .cfg_sel(cfg_sel), .cfg_data(cfg_data), .smp_vld(smp_vld),
        .smp_phase(smp_phase), .smp_code(smp_code), .smp_err(smp_err)
    );

    always #5 clk = ~clk;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    int lim_m[NCH];
    int edg_m[NCH];
    int gn_m[NCH];
    int rmp_m[NCH];
    int phs_m[NCH];

    int    q_ph[$];
    int    q_code[$];
    bit    q_err[$];
    string q_tag[$];

    logic [TAPS-1:0] cv[NCH];
    logic [NCH-1:0]  pv;

    task automatic chk(bit ok, string tag, int act, int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [TAPS-1:0] ones(int n);
        logic [TAPS-1:0] v = '0;
        for (int i = 0; i < n; i++) v[i] = 1'b1;
        return v;
    endfunction

    // expected corrected code, from the requirements
    function automatic int expect_code(logic [TAPS-1:0] code, bit pres, int ch, output bit err);
        logic [TAPS-1:0] m, f;
        int cnt, d, s;
        bit run;
        for (int i = 0; i < TAPS; i++) m[i] = (i < lim_m[ch]) ? code[i] : 1'b0;
        for (int i = 0; i < TAPS; i++)
            f[i] = m[i] | ((i > 0 && i < TAPS - 1) ? (m[i-1] & m[i+1]) : 1'b0);
        cnt = 0;
        run = 1'b1;
        for (int i = 0; i < TAPS; i++) begin
            run = run & f[i];
            if (run) cnt++;
        end
        err = !pres || (cnt == 0);
        if (err) return 0;
        d = cnt - edg_m[ch];
        s = (d * gn_m[ch]) >>> 8;
        s = s + rmp_m[ch] + phs_m[ch];
        if (s < 0) s = 0;
        if (s > 255) s = 255;
        return s;
    endfunction

    task automatic send(bit expect_it, string tag);
        bit e;
        int v;
        if (expect_it) begin
            for (int c = 0; c < NCH; c++) begin
                v = expect_code(cv[c], pv[c], c, e);
                q_ph.push_back(c);
                q_code.push_back(v);
                q_err.push_back(e);
                q_tag.push_back(tag);
            end
        end
        for (int c = 0; c < NCH; c++) frame_therm[c*TAPS +: TAPS] = cv[c];
        frame_present = pv;
        frame_vld = 1'b1;
        @(posedge clk);
        @(negedge clk);
        frame_vld = 1'b0;
    endtask

    task automatic wr(int ch, int sel, int data);
        cfg_wr = 1'b1;
        cfg_ch = 3'(ch);
        cfg_sel = 3'(sel);
        cfg_data = 9'(data);
        @(posedge clk);
        @(negedge clk);
        cfg_wr = 1'b0;
        if (ch < NCH) begin
            case (sel)
                0: lim_m[ch] = data & 8'h7f;
                1: edg_m[ch] = data & 8'h7f;
                2: gn_m[ch]  = data & 12'h1ff;
                3: rmp_m[ch] = int'($signed(8'(data)));
                4: phs_m[ch] = int'($signed(8'(data)));
                default: ;
            endcase
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && smp_vld && !done) begin
            if (q_ph.size() == 0) begin
                chk(1'b0, "R10 unexpected sample phase", int'(smp_phase), -1);
            end else begin
                int ep, ec;
                bit ee;
                string t;
                ep = q_ph.pop_front();
                ec = q_code.pop_front();
                ee = q_err.pop_front();
                t  = q_tag.pop_front();
                nchk++;
                if (int'(smp_phase) != ep || int'(smp_code) != ec || smp_err != ee) begin
                    nerr++;
                    $display("FAIL %s phase/code/err actual=%0d/%0d/%0d expected=%0d/%0d/%0d",
                             t, smp_phase, smp_code, smp_err, ep, ec, ee);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            nchk++;
            nerr++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < NCH; c++) begin
            lim_m[c] = TAPS; edg_m[c] = 0; gn_m[c] = 256; rmp_m[c] = 0; phs_m[c] = 0;
        end
        repeat (3) @(negedge clk);
        chk(smp_vld == 1'b0, "R1 valid low in reset", int'(smp_vld), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(smp_vld == 1'b0, "R1 valid low after reset", int'(smp_vld), 0);

        // frame 1: default coefficients, decode shapes (R1 R2 R3 R8)
        cv[0] = ones(10);
        cv[1] = ones(64);
        cv[2] = ones(20) & ~(64'd1 << 7);
        cv[3] = ones(20) & ~(64'h180);
        cv[4] = '0;
        cv[5] = ones(30);
        pv = 6'b011111;
        send(1'b1, "R2 R3 R8 frame1");
        repeat (6) @(negedge clk);
        chk(smp_vld == 1'b0, "R9 stream ends after six", int'(smp_vld), 0);

        // coefficient programming (R12), including ignored writes
        wr(0, 0, 12);
        wr(1, 1, 4);
        wr(2, 2, 384);
        wr(3, 3, 10);
        wr(3, 4, 9'h1fd);
        wr(4, 2, 511);
        wr(4, 3, 127);
        wr(4, 4, 127);
        wr(5, 1, 40);
        wr(7, 0, 1);
        wr(6, 1, 30);
        wr(0, 5, 3);
        wr(1, 7, 50);

        // frame 2: trim, edge, gain, offsets, clamps (R4 R5 R6 R7 R12)
        cv[0] = ones(30);
        cv[1] = ones(20);
        cv[2] = ones(21);
        cv[3] = ones(5);
        cv[4] = ones(64);
        cv[5] = ones(3);
        pv = 6'b111111;
        send(1'b1, "R4 R5 R6 R7 R12 frame2");
        repeat (8) @(negedge clk);

        // frame 3 with a mid-frame write, then back-to-back frame 4 (R11 R10 R4)
        wr(0, 0, 0);
        cv[0] = ones(5);
        send(1'b1, "R11 R4 frame3 old gain");
        wr(2, 2, 128);
        repeat (4) @(negedge clk);
        cv[1] = ones(20) & ~(64'd1 << 2);
        send(1'b1, "R11 R3 R10 frame4 new gain");
        repeat (8) @(negedge clk);

        // frame 5, then a frame offered while busy must be ignored (R10)
        wr(0, 0, 64);
        cv[0] = ones(9);
        cv[2] = ones(40);
        send(1'b1, "R10 frame5");
        for (int c = 0; c < NCH; c++) cv[c] = ones(2);
        pv = 6'b000001;
        send(1'b0, "R10 dropped");
        repeat (8) @(negedge clk);
        chk(smp_vld == 1'b0, "R10 no samples from dropped frame", int'(smp_vld), 0);
        chk(q_ph.size() == 0, "R9 all expected samples seen", q_ph.size(), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule